// File: doc/BRIEF.md
# Data hazard stall controller

This block sits beside the issue stage of a small in-order pipeline with several issue points. Every cycle it looks at the operations offered at each point: their source registers, their destination register, whether they write, and whether a bypass path can supply their operands. It compares them against each other and against a scoreboard of writers that have issued but not yet written back. Each dependency is sorted into one of three classes: read-after-write (RAW), write-after-read (WAR) or write-after-write (WAW).

Each issue point has its own programmable response code. The code decides how strongly the pipeline reacts when that point finds a hazard. The levels range from doing nothing, through stalling the single operation, the detecting unit or its own pipe, up to freezing the whole machine. When several points see hazards in one cycle, the strongest of their codes drives the stall outputs. The block also reports which operations may issue, and keeps its scoreboard up to date from those grants and from the write-back port.

Issue point 0 holds the oldest operation of a cycle and higher indices hold younger ones. The outputs are combinational in the current inputs and in the registered state.

Top module: `hzd_stall_ctrl`

## Requirements
- R1: A valid operation at point p reports RAW when either of its sources names a register that is pending in the scoreboard and is not being written back this cycle, or that matches the destination of a valid writer at a lower point in the same cycle.
- R2: A valid writer at point p reports WAR when its destination equals a source of a valid operation at a lower point in the same cycle.
- R3: A valid writer at point p reports WAW when its destination is pending and not being written back this cycle, or equals the destination of a valid writer at a lower point.
- R4: Two operations that only read the same registers never report any hazard.
- R5: When an operation's bypass flag is set, it never reports RAW.
- R6: While rename_en is 1, WAR and WAW are never reported.
- R7: Response codes are 3 bits: 0 none, 1 operation, 2 unit, 3 pipe, 4 global. Every point resets to 4. A configuration write takes effect from the next cycle, and a written value above 4 is stored as 4.
- R8: Take the largest code among the points that report any hazard. The stall outputs stall_op, stall_unit, stall_pipe and stall_all are one-hot for levels 1 to 4, and all four are 0 at level 0 or when no point reports a hazard.
- R9: issue_ok[p] is 1 exactly when point p is valid, stall_all is 0, and point p either reports no hazard or holds code 0.
- R10: A writer granted by issue_ok marks its destination pending from the next cycle. A write-back clears that mark from the next cycle, and a read or write of that register in the write-back cycle itself counts as forwarded and raises no hazard from the scoreboard.
- R11: When a granted writer and a write-back name the same register in one cycle, the register stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Response code write strobe |
| cfg_sel | input | SELW | Issue point whose code is written |
| cfg_code | input | 3 | New response code |
| rename_en | input | 1 | Renaming active; suppresses WAR and WAW |
| op_valid | input | NPORT | Operation present at each point |
| op_wr | input | NPORT | Operation writes its destination |
| op_byp | input | NPORT | Bypass can supply the operation's sources |
| op_src_a | input | NPORT*AW | First source register per point |
| op_src_b | input | NPORT*AW | Second source register per point |
| op_dst | input | NPORT*AW | Destination register per point |
| wb_valid | input | 1 | A write-back completes this cycle |
| wb_reg | input | AW | Register written back |
| haz_raw | output | NPORT | RAW seen at each point |
| haz_war | output | NPORT | WAR seen at each point |
| haz_waw | output | NPORT | WAW seen at each point |
| stall_op | output | 1 | Stall the offending operation |
| stall_unit | output | 1 | Stall the detecting unit |
| stall_pipe | output | 1 | Stall the detecting pipe |
| stall_all | output | 1 | Freeze every pipe |
| issue_ok | output | NPORT | Operation at each point issues this cycle |

## Verification
Some properties hold on every cycle whatever the traffic, and the assertions watch those. The stall outputs never assert more than one level. No stall appears without a reported hazard. Bypass silences RAW and renaming silences WAR and WAW. A global stall blocks every grant. Other behaviours depend on history and on correct values, and only the bench's scenarios and its reference model can show them. These include the scoreboard life cycle, forwarding in the write-back cycle, the set-over-clear priority, the reset and clamping of response codes, and the choice of the strongest code across points. The bench walks every hazard class through all five codes, with and without bypass and renaming, and then runs randomized traffic.

// File: rtl/hzd_stall_ctrl.sv
module hzd_stall_ctrl #(
  parameter int NPORT = 3,
  parameter int NREG  = 16,
  parameter int AW    = $clog2(NREG),
  parameter int SELW  = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SELW-1:0]     cfg_sel,
  input  logic [2:0]          cfg_code,
  input  logic                rename_en,
  input  logic [NPORT-1:0]    op_valid,
  input  logic [NPORT-1:0]    op_wr,
  input  logic [NPORT-1:0]    op_byp,
  input  logic [NPORT*AW-1:0] op_src_a,
  input  logic [NPORT*AW-1:0] op_src_b,
  input  logic [NPORT*AW-1:0] op_dst,
  input  logic                wb_valid,
  input  logic [AW-1:0]       wb_reg,
  output logic [NPORT-1:0]    haz_raw,
  output logic [NPORT-1:0]    haz_war,
  output logic [NPORT-1:0]    haz_waw,
  output logic                stall_op,
  output logic                stall_unit,
  output logic                stall_pipe,
  output logic                stall_all,
  output logic [NPORT-1:0]    issue_ok
);
  localparam logic [2:0] LVL_TOP = 3'd4;

  logic [2:0]      code_q [NPORT];
  logic [NREG-1:0] pend_q, pend_eff, wb_mask, set_mask;
  logic [2:0]      act_lvl;
  logic [NPORT-1:0] hz_any;

  assign wb_mask  = wb_valid ? (NREG'(1) << wb_reg) : '0;
  assign pend_eff = pend_q & ~wb_mask;

  always_comb begin
    haz_raw = '0;
    haz_war = '0;
    haz_waw = '0;
    for (int p = 0; p < NPORT; p++) begin
      logic [AW-1:0] sa, sb, dd;
      logic r, a, w;
      sa = op_src_a[p*AW +: AW];
      sb = op_src_b[p*AW +: AW];
      dd = op_dst[p*AW +: AW];
      r = pend_eff[sa] | pend_eff[sb];
      w = pend_eff[dd];
      a = 1'b0;
      for (int q = 0; q < p; q++) begin
        if (op_valid[q]) begin
          if (op_wr[q]) begin
            r = r | (op_dst[q*AW +: AW] == sa) | (op_dst[q*AW +: AW] == sb);
            w = w | (op_dst[q*AW +: AW] == dd);
          end
          a = a | (op_src_a[q*AW +: AW] == dd) | (op_src_b[q*AW +: AW] == dd);
        end
      end
      haz_raw[p] = op_valid[p] & ~op_byp[p] & r;
      haz_war[p] = op_valid[p] & op_wr[p] & ~rename_en & a;
      haz_waw[p] = op_valid[p] & op_wr[p] & ~rename_en & w;
    end
  end

  assign hz_any = haz_raw | haz_war | haz_waw;

  always_comb begin
    act_lvl = 3'd0;
    for (int p = 0; p < NPORT; p++)
      if (hz_any[p] && code_q[p] > act_lvl) act_lvl = code_q[p];
  end

  assign stall_op   = (act_lvl == 3'd1);
  assign stall_unit = (act_lvl == 3'd2);
  assign stall_pipe = (act_lvl == 3'd3);
  assign stall_all  = (act_lvl == LVL_TOP);

  always_comb begin
    set_mask = '0;
    for (int p = 0; p < NPORT; p++) begin
      issue_ok[p] = op_valid[p] & ~stall_all & ~(hz_any[p] & (code_q[p] != 3'd0));
      if (issue_ok[p] && op_wr[p]) set_mask = set_mask | (NREG'(1) << op_dst[p*AW +: AW]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int p = 0; p < NPORT; p++) code_q[p] <= LVL_TOP;
    end else begin
      pend_q <= pend_eff | set_mask;
      if (cfg_we && int'(cfg_sel) < NPORT)
        code_q[cfg_sel] <= (cfg_code > LVL_TOP) ? LVL_TOP : cfg_code;
    end
  end
endmodule

module hzd_stall_ctrl_chk #(
  parameter int NPORT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rename_en,
  input logic [NPORT-1:0] op_valid,
  input logic [NPORT-1:0] op_byp,
  input logic [NPORT-1:0] haz_raw,
  input logic [NPORT-1:0] haz_war,
  input logic [NPORT-1:0] haz_waw,
  input logic             stall_op,
  input logic             stall_unit,
  input logic             stall_pipe,
  input logic             stall_all,
  input logic [NPORT-1:0] issue_ok
);
  AST_STALL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stall_op, stall_unit, stall_pipe, stall_all})); // R8
  AST_NO_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((haz_raw | haz_war | haz_waw) == '0) |-> !(stall_op | stall_unit | stall_pipe | stall_all)); // R8
  AST_BYPASS_NO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_byp & haz_raw) == '0); // R5
  AST_RENAME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rename_en |-> ((haz_war | haz_waw) == '0)); // R6
  AST_GLOBAL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    stall_all |-> (issue_ok == '0)); // R9
  AST_GRANT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ok & ~op_valid) == '0); // R9
endmodule

bind hzd_stall_ctrl hzd_stall_ctrl_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rename_en(rename_en), .op_valid(op_valid),
  .op_byp(op_byp), .haz_raw(haz_raw), .haz_war(haz_war), .haz_waw(haz_waw),
  .stall_op(stall_op), .stall_unit(stall_unit), .stall_pipe(stall_pipe),
  .stall_all(stall_all), .issue_ok(issue_ok));

// File: tb/hzd_stall_ctrl_test.sv
module hzd_stall_ctrl_test;
  localparam int NP = 3;
  localparam int NR = 16;
  localparam int AW = 4;
  localparam int SW = 2;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic cfg_we = 0, rename_en = 0, wb_valid = 0;
  logic [SW-1:0] cfg_sel = '0;
  logic [2:0] cfg_code = '0;
  logic [AW-1:0] wb_reg = '0;
  logic [NP-1:0] v = '0, w = '0, b = '0;
  logic [AW-1:0] sa [NP], sb [NP], d [NP];
  logic [NP*AW-1:0] psa, psb, pd;
  logic [NP-1:0] raw, war, waw, ok;
  logic s_op, s_un, s_pi, s_al;

  always_comb
    for (int p = 0; p < NP; p++) begin
      psa[p*AW +: AW] = sa[p];
      psb[p*AW +: AW] = sb[p];
      pd[p*AW +: AW]  = d[p];
    end

  hzd_stall_ctrl #(.NPORT(NP), .NREG(NR)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_code(cfg_code),
    .rename_en(rename_en), .op_valid(v), .op_wr(w), .op_byp(b),
    .op_src_a(psa), .op_src_b(psb), .op_dst(pd), .wb_valid(wb_valid), .wb_reg(wb_reg),
    .haz_raw(raw), .haz_war(war), .haz_waw(waw), .stall_op(s_op), .stall_unit(s_un),
    .stall_pipe(s_pi), .stall_all(s_al), .issue_ok(ok));

  int checks = 0, failures = 0;
  bit done = 0;
  bit pend [NR];
  int codes [NP];
  logic [NP-1:0] e_raw, e_war, e_waw, e_ok;
  logic [3:0] e_st;

  task automatic model_eval();
    int lvl;
    bit pe [NR];
    lvl = 0;
    for (int r = 0; r < NR; r++) pe[r] = pend[r] && !(wb_valid && int'(wb_reg) == r);
    for (int p = 0; p < NP; p++) begin
      bit r1, a1, w1;
      r1 = pe[sa[p]] || pe[sb[p]];
      w1 = pe[d[p]];
      a1 = 0;
      for (int q = 0; q < p; q++) if (v[q]) begin
        if (w[q] && (d[q] == sa[p] || d[q] == sb[p])) r1 = 1;
        if (w[q] && d[q] == d[p]) w1 = 1;
        if (sa[q] == d[p] || sb[q] == d[p]) a1 = 1;
      end
      e_raw[p] = v[p] && !b[p] && r1;
      e_war[p] = v[p] && w[p] && !rename_en && a1;
      e_waw[p] = v[p] && w[p] && !rename_en && w1;
      if ((e_raw[p] || e_war[p] || e_waw[p]) && codes[p] > lvl) lvl = codes[p];
    end
    e_st = (lvl == 0) ? 4'b0000 : 4'(1 << (lvl - 1));
    for (int p = 0; p < NP; p++)
      e_ok[p] = v[p] && lvl != 4 && !((e_raw[p] || e_war[p] || e_waw[p]) && codes[p] != 0);
  endtask

  task automatic model_update();
    bit nx [NR];
    for (int r = 0; r < NR; r++) nx[r] = pend[r] && !(wb_valid && int'(wb_reg) == r);
    for (int p = 0; p < NP; p++) if (e_ok[p] && w[p]) nx[d[p]] = 1;
    pend = nx;
    if (cfg_we) codes[cfg_sel] = (cfg_code > 4) ? 4 : int'(cfg_code);
  endtask

  task automatic idle();
    v = '0; w = '0; b = '0; cfg_we = 0; wb_valid = 0;
    for (int p = 0; p < NP; p++) begin sa[p] = 4'(12 + p); sb[p] = 4'(12 + p); d[p] = 4'(12 + p); end
  endtask

  task automatic step(input string tag);
    #1;
    model_eval();
    checks++;
    if ({raw, war, waw, s_al, s_pi, s_un, s_op, ok} !== {e_raw, e_war, e_waw, e_st, e_ok}) begin
      failures++;
      $display("FAIL %s raw/war/waw/stall/ok act=%b/%b/%b/%b%b%b%b/%b exp=%b/%b/%b/%b/%b",
               tag, raw, war, waw, s_al, s_pi, s_un, s_op, ok, e_raw, e_war, e_waw, e_st, e_ok);
    end
    @(posedge clk);
    model_update();
    @(negedge clk);
    idle();
  endtask

  task automatic drain();
    for (int r = 0; r < NR; r++) begin wb_valid = 1; wb_reg = 4'(r); step("R10"); end
  endtask

  task automatic set_all(input int c);
    for (int p = 0; p < NP; p++) begin
      cfg_we = 1; cfg_sel = 2'(p); cfg_code = 3'(c); step("R7");
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) codes[p] = 4;
    for (int r = 0; r < NR; r++) pend[r] = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("R7 reset state");
    // R7: reset code is global; writer then dependent reader
    v[0] = 1; w[0] = 1; d[0] = 5; sa[0] = 1; sb[0] = 2; step("R10 writer grant");
    v[0] = 1; sa[0] = 5; sb[0] = 1; step("R7 RAW at reset code");
    drain();
    // R4 read after read
    v = 3'b011; sa[0] = 2; sb[0] = 3; sa[1] = 2; sb[1] = 3; d[0] = 2; d[1] = 3; step("R4");
    // every class x code x bypass x rename
    for (int c = 0; c < 5; c++) begin
      set_all(c);
      for (int bp = 0; bp < 2; bp++)
        for (int rn = 0; rn < 2; rn++) begin
          v[0] = 1; w[0] = 1; d[0] = 3; sa[0] = 8; sb[0] = 9; rename_en = 1'(rn); step("R10");
          v[1] = 1; sa[1] = 3; sb[1] = 9; b[1] = 1'(bp); rename_en = 1'(rn); step("R1 R5 RAW");
          v = 3'b011; sa[0] = 4; sb[0] = 8; w[1] = 1; d[1] = 4; sa[1] = 10; sb[1] = 11;
          b[1] = 1'(bp); rename_en = 1'(rn); step("R2 R6 WAR");
          v = 3'b011; w = 3'b011; d[0] = 6; d[1] = 6; sa[0] = 8; sb[0] = 9; sa[1] = 10; sb[1] = 11;
          rename_en = 1'(rn); step("R3 R6 WAW");
          v[2] = 1; w[2] = 1; d[2] = 3; sa[2] = 8; sb[2] = 9; rename_en = 1'(rn); step("R3 pending WAW");
          rename_en = 0;
          drain();
        end
    end
    // R8 strongest among points
    cfg_we = 1; cfg_sel = 0; cfg_code = 1; step("R7");
    cfg_we = 1; cfg_sel = 2; cfg_code = 3; step("R7");
    v[1] = 1; w[1] = 1; d[1] = 7; sa[1] = 8; sb[1] = 9; step("R10");
    v = 3'b101; sa[0] = 7; sb[0] = 8; sa[2] = 7; sb[2] = 9; step("R8 strongest pipe");
    v = 3'b001; sa[0] = 7; sb[0] = 8; step("R8 op level");
    // R10 forwarding on write-back cycle
    v = 3'b101; sa[0] = 7; sb[0] = 8; w[2] = 1; d[2] = 7; sa[2] = 1; sb[2] = 1;
    wb_valid = 1; wb_reg = 7; step("R10 forwarded");
    v[0] = 1; sa[0] = 7; sb[0] = 8; step("R10 after rewrite");
    drain();
    // R11 set wins over clear
    cfg_we = 1; cfg_sel = 0; cfg_code = 0; step("R7");
    v[0] = 1; w[0] = 1; d[0] = 9; sa[0] = 1; sb[0] = 1; step("R10");
    v[0] = 1; w[0] = 1; d[0] = 9; sa[0] = 1; sb[0] = 1; wb_valid = 1; wb_reg = 9; step("R11 set and clear");
    v[0] = 1; sa[0] = 9; sb[0] = 1; step("R11 still pending");
    drain();
    // R7 clamp of code above 4
    cfg_we = 1; cfg_sel = 1; cfg_code = 6; step("R7 clamp write");
    v[0] = 1; w[0] = 1; d[0] = 2; sa[0] = 0; sb[0] = 1; v[1] = 1; sa[1] = 2; sb[1] = 0;
    step("R7 clamped acts global");
    // R9 random traffic
    for (int i = 0; i < 400; i++) begin
      v = 3'($urandom); w = 3'($urandom); b = 3'($urandom);
      rename_en = ($urandom % 4) == 0;
      for (int p = 0; p < NP; p++) begin
        sa[p] = 4'($urandom % 6); sb[p] = 4'($urandom % 6); d[p] = 4'($urandom % 6);
      end
      wb_valid = 1'($urandom); wb_reg = 4'($urandom % 6);
      cfg_we = ($urandom % 8) == 0; cfg_sel = 2'($urandom % 3); cfg_code = 3'($urandom);
      step("R9 random");
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule